// File: doc/BRIEF.md
# DRAM Refresh Request Controller

This block decides when a dynamic memory needs a refresh cycle and hands that refresh to the memory's access arbiter. A free-running interval timer counts clock cycles up to a terminal count. That count comes from a clock-frequency parameter and from a configuration bit that picks either a 13 µs or a 15 µs interval. Each time the interval elapses, an interval flag is set. The flag stays set until a refresh is granted, so no interval is lost while the arbiter is busy with a normal access.

With the disable input low, the block runs refreshes by itself. It raises a request to the arbiter as soon as the flag is set, holds the request until it sees a grant, and then drives the refresh-active output for a fixed number of cycles.

With the disable input high, internal refreshes are held back and the external refresh input takes over. A single pulse on that input requests one refresh. Holding it high produces back-to-back refreshes. When the disable input is low, the external input does not request a refresh; instead it clears the refresh row counter, which is useful before a burst.

One status output serves two purposes, chosen by a configuration bit. It can report that a refresh is in progress, or it can report that the interval has elapsed.

Top module: `refresh_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `rf_req`, `rf_active` and `status_out` are 0 and `row_addr` is 0.
- R2: The interval flag is set at the end of cycle CLK_MHZ*13 counted from reset release when `cfg_long_interval`=0, and CLK_MHZ*15 when it is 1. With `cfg_status_sel`=0, `status_out` rises at that point.
- R3: With `cfg_status_sel`=0, `status_out` stays high until a refresh grant is accepted, and is low once that refresh is under way.
- R4: With `refresh_disable`=0, a set interval flag raises `rf_req`. `rf_req` stays high on every cycle until `rf_gnt` is sampled high, so a busy arbiter only delays the refresh.
- R5: The cycle after `rf_req` and `rf_gnt` are both high, `rf_req` falls and `rf_active` is high for exactly ACT_CYCLES consecutive cycles.
- R6: With `cfg_status_sel`=1, `status_out` is high from the first cycle of `rf_req` through the last cycle of `rf_active`, and low once `rf_active` has fallen.
- R7: With `refresh_disable`=1, an elapsed interval never raises `rf_req` on its own.
- R8: With `refresh_disable`=1, `ext_refresh` high requests a refresh. Holding it high produces consecutive refreshes, and none start after it has been released.
- R9: `ext_refresh` high while `refresh_disable`=0 sets `row_addr` to 0 at the next edge and requests no refresh.
- R10: `row_addr` increases by one at the edge that ends each refresh and goes from ROWS-1 back to 0. It does not change otherwise, except through R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_status_sel | input | 1 | Status meaning: 1 = refresh in progress, 0 = interval elapsed |
| cfg_long_interval | input | 1 | Interval select: 0 = 13 µs, 1 = 15 µs |
| refresh_disable | input | 1 | 1 = suppress internal refresh and accept external requests |
| ext_refresh | input | 1 | External refresh request, or row-counter clear when `refresh_disable`=0 |
| rf_gnt | input | 1 | Grant from the access arbiter; memory may be used for refresh |
| rf_req | output | 1 | Refresh request to the arbiter |
| rf_active | output | 1 | Refresh cycle running (row strobe window) |
| status_out | output | 1 | Configurable status: refresh in progress or interval elapsed |
| row_addr | output | ROW_W | Refresh row address |

## Verification
The checker watches, on every cycle, that a request is held until it is granted, that a grant is followed at once by the active window, that the window is exactly ACT_CYCLES long, and that in-progress status is up before the window opens. It also checks that a request never starts with refresh disabled and the external input low, and that the row address steps, wraps or clears only when it should. The bench scenarios cover what needs a longer view: the exact 13 µs and 15 µs interval lengths, an interval flag that survives a slow grant, status in request mode staying up across many cycles and then dropping after a grant, and a held external input giving a burst that wraps the row counter and stops when the input is released.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ASK  = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

  localparam int SHORT_US = 13;
  localparam int LONG_US  = 15;

  function automatic int interval_cycles(input int mhz, input logic long_sel);
    return mhz * (long_sel ? LONG_US : SHORT_US);
  endfunction

endpackage

// File: rtl/rfc_interval_timer.sv
module rfc_interval_timer #(
  parameter int CLK_MHZ = 25,
  localparam int CNT_W = $clog2(rfc_pkg::LONG_US * CLK_MHZ + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic long_sel,
  output logic tick
);
  localparam logic [CNT_W-1:0] LAST_SHORT =
    CNT_W'(rfc_pkg::interval_cycles(CLK_MHZ, 1'b0) - 1);
  localparam logic [CNT_W-1:0] LAST_LONG =
    CNT_W'(rfc_pkg::interval_cycles(CLK_MHZ, 1'b1) - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb begin
    last = long_sel ? LAST_LONG : LAST_SHORT;
    tick = (cnt >= last);
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfc_sequencer.sv
module rfc_sequencer #(
  parameter int ACT_CYCLES = 4,
  localparam int AC_W = (ACT_CYCLES > 1) ? $clog2(ACT_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic refresh_disable,
  input  logic ext_refresh,
  input  logic rf_gnt,
  output logic rf_req,
  output logic rf_active,
  output logic intv_flag,
  output logic done
);
  import rfc_pkg::*;

  localparam logic [AC_W-1:0] LAST = AC_W'(ACT_CYCLES - 1);

  seq_state_e state, state_nxt;
  logic [AC_W-1:0] act_cnt;
  logic int_want, ext_want, take;

  always_comb begin
    int_want  = intv_flag & ~refresh_disable;
    ext_want  = ext_refresh & refresh_disable;
    take      = (state == SEQ_ASK) & rf_gnt;
    done      = (state == SEQ_RUN) & (act_cnt == LAST);
    rf_req    = (state == SEQ_ASK);
    rf_active = (state == SEQ_RUN);
    state_nxt = state;
    case (state)
      SEQ_IDLE: if (int_want | ext_want) state_nxt = SEQ_ASK;
      SEQ_ASK:  if (rf_gnt)              state_nxt = SEQ_RUN;
      SEQ_RUN:  if (done)                state_nxt = SEQ_IDLE;
      default:                           state_nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      act_cnt   <= '0;
      intv_flag <= 1'b0;
    end else begin
      state <= state_nxt;
      if (state == SEQ_RUN && !done) act_cnt <= act_cnt + 1'b1;
      else                           act_cnt <= '0;
      if (tick)      intv_flag <= 1'b1;
      else if (take) intv_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rfc_row_counter.sv
module rfc_row_counter #(
  parameter int ROWS = 512,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_step;

  generate
    if ((1 << ROW_W) == ROWS) begin : g_pow2
      always_comb row_step = row + 1'b1;
    end else begin : g_cmp
      localparam logic [ROW_W-1:0] TOP = ROW_W'(ROWS - 1);
      always_comb row_step = (row == TOP) ? '0 : row + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) row <= '0;
    else if (inc)   row <= row_step;
  end
endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl #(
  parameter int CLK_MHZ    = 25,
  parameter int ROWS       = 512,
  parameter int ACT_CYCLES = 4,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_status_sel,
  input  logic             cfg_long_interval,
  input  logic             refresh_disable,
  input  logic             ext_refresh,
  input  logic             rf_gnt,
  output logic             rf_req,
  output logic             rf_active,
  output logic             status_out,
  output logic [ROW_W-1:0] row_addr
);
  logic tick, intv_flag, done, row_clr;

  rfc_interval_timer #(.CLK_MHZ(CLK_MHZ)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .long_sel (cfg_long_interval),
    .tick     (tick)
  );

  rfc_sequencer #(.ACT_CYCLES(ACT_CYCLES)) u_seq (
    .clk             (clk),
    .rst             (rst),
    .tick            (tick),
    .refresh_disable (refresh_disable),
    .ext_refresh     (ext_refresh),
    .rf_gnt          (rf_gnt),
    .rf_req          (rf_req),
    .rf_active       (rf_active),
    .intv_flag       (intv_flag),
    .done            (done)
  );

  assign row_clr = ext_refresh & ~refresh_disable;

  rfc_row_counter #(.ROWS(ROWS)) u_rows (
    .clk (clk),
    .rst (rst),
    .clr (row_clr),
    .inc (done),
    .row (row_addr)
  );

  // status is a decode of registered state only
  assign status_out = cfg_status_sel ? (rf_req | rf_active) : intv_flag;
endmodule

// File: rtl/refresh_ctrl_chk.sv
module refresh_ctrl_chk #(
  parameter int ROWS       = 512,
  parameter int ACT_CYCLES = 4,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_status_sel,
  input logic             refresh_disable,
  input logic             ext_refresh,
  input logic             rf_gnt,
  input logic             rf_req,
  input logic             rf_active,
  input logic             status_out,
  input logic [ROW_W-1:0] row_addr
);
  int run_len;

  always_ff @(posedge clk) begin
    if (rst)            run_len <= 0;
    else if (rf_active) run_len <= run_len + 1;
    else                run_len <= 0;
  end

  function automatic logic [ROW_W-1:0] row_next(input logic [ROW_W-1:0] r);
    return (int'(r) == ROWS - 1) ? '0 : r + 1'b1;
  endfunction

  // R4
  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    rf_req && !rf_gnt |=> rf_req);

  // R5
  a_r5_grant_opens: assert property (@(posedge clk) disable iff (rst)
    rf_req && rf_gnt |=> rf_active && !rf_req);

  // R5
  a_r5_window_len: assert property (@(posedge clk) disable iff (rst)
    $fell(rf_active) |-> run_len == ACT_CYCLES);

  // R6
  a_r6_status_leads: assert property (@(posedge clk) disable iff (rst)
    cfg_status_sel && $past(cfg_status_sel) && $rose(rf_active) |-> $past(status_out));

  // R7
  a_r7_no_self_start: assert property (@(posedge clk) disable iff (rst)
    $rose(rf_req) |-> $past(!refresh_disable || ext_refresh));

  // R9
  a_r9_row_clear: assert property (@(posedge clk) disable iff (rst)
    $past(ext_refresh && !refresh_disable) |-> row_addr == '0);

  // R10
  a_r10_row_step: assert property (@(posedge clk) disable iff (rst)
    $fell(rf_active) && !$past(ext_refresh && !refresh_disable)
      |-> row_addr == row_next($past(row_addr)));

  // R10
  a_r10_row_hold: assert property (@(posedge clk) disable iff (rst)
    !$fell(rf_active) && !$past(ext_refresh && !refresh_disable)
      |-> $stable(row_addr));
endmodule

bind refresh_ctrl refresh_ctrl_chk #(.ROWS(ROWS), .ACT_CYCLES(ACT_CYCLES)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cfg_status_sel  (cfg_status_sel),
  .refresh_disable (refresh_disable),
  .ext_refresh     (ext_refresh),
  .rf_gnt          (rf_gnt),
  .rf_req          (rf_req),
  .rf_active       (rf_active),
  .status_out      (status_out),
  .row_addr        (row_addr)
);

// File: tb/test_refresh_ctrl.sv
`timescale 1ns/1ps
module test_refresh_ctrl;
  localparam int CLK_MHZ = 2;
  localparam int ROWS    = 5;
  localparam int ACT     = 3;
  localparam int ROW_W   = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_status_sel = 1'b0;
  logic cfg_long_interval = 1'b0;
  logic refresh_disable = 1'b1;
  logic ext_refresh = 1'b0;
  logic rf_gnt = 1'b0;
  logic rf_req, rf_active, status_out;
  logic [ROW_W-1:0] row_addr;

  always #2 clk = ~clk;

  refresh_ctrl #(.CLK_MHZ(CLK_MHZ), .ROWS(ROWS), .ACT_CYCLES(ACT)) i_refresh_ctrl (
    .clk(clk), .rst(rst), .cfg_status_sel(cfg_status_sel),
    .cfg_long_interval(cfg_long_interval), .refresh_disable(refresh_disable),
    .ext_refresh(ext_refresh), .rf_gnt(rf_gnt), .rf_req(rf_req),
    .rf_active(rf_active), .status_out(status_out), .row_addr(row_addr)
  );

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int exp_row = 0;
  int gnt_delay = 1;
  int exp_req_len = 1;
  int req_rises = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // driver side of the scoreboard: one entry per expected refresh
  task automatic push_refresh();
    exp_row = (exp_row + 1) % ROWS;
    exp_q.push_back(exp_row);
  endtask

  // arbiter model
  int wcnt = 0;
  always @(negedge clk) begin
    if (rst || !rf_req) begin
      rf_gnt = 1'b0;
      wcnt = 0;
    end else if (!rf_gnt) begin
      wcnt++;
      if (wcnt >= gnt_delay) rf_gnt = 1'b1;
    end
  end

  // monitor side of the scoreboard
  logic req_prev = 0, act_prev = 0, stat_prev = 0;
  int req_len = 0, act_len = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rf_req && !req_prev) req_rises++;
      if (rf_req) req_len++;
      if (rf_active && !act_prev) begin
        check(req_len == exp_req_len, "R4 request held until grant", req_len, exp_req_len);
        if (cfg_status_sel)
          check(stat_prev == 1'b1, "R6 status before active", stat_prev, 1);
        req_len = 0;
      end
      if (rf_active) act_len++;
      if (!rf_active && act_prev) begin
        check(act_len == ACT, "R5 active window length", act_len, ACT);
        act_len = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected refresh", 1, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(row_addr) == e, "R10 row after refresh", int'(row_addr), e);
        end
        if (cfg_status_sel)
          check(status_out == 1'b0, "R6 status low after active", status_out, 0);
      end
      req_prev = rf_req;
      act_prev = rf_active;
      stat_prev = status_out;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_row = 0;
  endtask

  task automatic measure_interval(input int expv, input string tag);
    int n = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (status_out) break;
    end
    check(n == expv, tag, n, expv);
  endtask

  task automatic wait_drain(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      #1;
      if (exp_q.size() == 0) break;
    end
    check(exp_q.size() == 0, "R8 expected refreshes completed", exp_q.size(), 0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0;
    // R1 reset state
    @(negedge clk);
    check(rf_req == 0 && rf_active == 0 && status_out == 0, "R1 outputs in reset",
          {rf_req, rf_active, status_out}, 0);
    do_reset();
    check(row_addr == 0 && !rf_req && !rf_active && !status_out, "R1 after release",
          int'(row_addr), 0);

    // R2 short interval, R7 suppression, R3 status held
    measure_interval(CLK_MHZ * 13, "R2 13us interval");
    repeat (40) @(negedge clk);
    check(req_rises == 0, "R7 no internal refresh when disabled", req_rises, 0);
    check(status_out == 1'b1, "R3 request status held", status_out, 1);

    // R2 long interval
    cfg_long_interval = 1'b1;
    do_reset();
    measure_interval(CLK_MHZ * 15, "R2 15us interval");

    // R4 internal refresh with slow grant, repeated intervals
    gnt_delay = 5;
    exp_req_len = 5;
    push_refresh();
    push_refresh();
    push_refresh();
    refresh_disable = 1'b0;
    wait_drain(300);
    check(status_out == 1'b0, "R3 request status cleared by grant", status_out, 0);

    // R9 clear row counter, no refresh
    r0 = req_rises;
    ext_refresh = 1'b1;
    @(negedge clk);
    ext_refresh = 1'b0;
    refresh_disable = 1'b1;
    check(row_addr == 0, "R9 row cleared", int'(row_addr), 0);
    exp_row = 0;
    repeat (2) @(negedge clk);
    check(req_rises == r0, "R9 no refresh from clear", req_rises, r0);

    // R8 burst with in-progress status, R10 wrap, R6
    cfg_status_sel = 1'b1;
    gnt_delay = 1;
    exp_req_len = 1;
    for (int k = 0; k < 5; k++) push_refresh();
    check(exp_row == 0, "R10 burst ends on wrapped row", exp_row, 0);
    ext_refresh = 1'b1;
    wait_drain(300);
    ext_refresh = 1'b0;
    r0 = req_rises;
    repeat (60) @(negedge clk);
    check(req_rises == r0, "R8 burst stops on release", req_rises, r0);
    check(status_out == 1'b0, "R6 status low when idle", status_out, 0);
    check(int'(row_addr) == 0, "R10 row wrapped to zero", int'(row_addr), 0);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule